// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Subsystem

This block gives two to four requesting cores each a small private, direct-mapped, write-back cache, and keeps those caches coherent over one shared broadcast bus in front of one backing memory. Every cache watches every bus transaction. When a core wants to write a line it does not own exclusively, its cache first broadcasts an ownership request that removes all other copies. When a core misses on a read, the cache holding the line dirty answers in place of memory. Reads and writes to lines a cache already owns strongly enough complete locally, with no bus activity.

Each core presents one request at a time: a valid flag, a read/write select, an address and write data. The core holds the request until a one-cycle response pulse arrives with the data. A round-robin arbiter picks one core, and that core's whole transaction finishes before the next grant. This serial handling orders all writes to an address the same way for every core. The bus command, bus address and a dirty-owner flag are visible as outputs, so the bus can be observed.

Top module: `snoopy_coh`

## Requirements
- R1: After reset every cache line is Invalid, every memory word is zero, no response is pending and the bus command is idle (code 0), so the first read of any address returns 0.
- R2: A read that misses its cache drives bus command 1 (read) with the request address for one cycle and fills the line as Shared. The response pulse comes 3 clock edges after the request is first sampled high, and the fill takes the data from memory unless R7 applies.
- R3: A read that hits a Shared or Modified line returns the cached data 2 edges after the request, with the bus idle throughout.
- R4: A write that hits a line the cache holds Modified updates the line 2 edges after the request, with no bus command.
- R5: A write that hits a Shared line drives bus command 3 (upgrade), after which the line is Modified and every other copy is Invalid. A later read of that address by any other core misses and returns the newly written value.
- R6: A write that misses drives bus command 2 (read-for-ownership), invalidates every other copy and leaves the writer's line Modified. At most one cache holds an address Modified at any time.
- R7: When a read or read-for-ownership targets an address another cache holds Modified, that cache supplies the data and the intervention output is high in the bus cycle. On a read the owner drops to Shared and memory takes the supplied value. On a read-for-ownership the owner drops to Invalid.
- R8: The line index is the low address bits. A miss whose line holds a different address in Modified state first drives bus command 4 (writeback) carrying the victim's address for one cycle, then the fill command, with the response 4 edges after the request. A clean victim is dropped silently.
- R9: Round-robin arbitration: after reset core 0 has top priority, and after a grant to core k, core k+1 (mod the core count) has it. One transaction completes before the next grant, so simultaneous writes to one address take effect in grant order for every core.
- R10: A core holds its request until its one-cycle response pulse. At most one response pulse is high per cycle. The response data is the read value, or the write data for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| reqValid | input | N_CORES | Per-core request valid, held until the response |
| reqWrite | input | N_CORES | Per-core request type, 1 = write |
| reqAddr | input | N_CORES*ADDR_W | Per-core word address, core c in slice c |
| reqWData | input | N_CORES*DATA_W | Per-core write data |
| respValid | output | N_CORES | Per-core one-cycle response pulse |
| respData | output | N_CORES*DATA_W | Per-core response data, valid with respValid |
| busCmd | output | 3 | Bus command: 0 idle, 1 read, 2 read-for-ownership, 3 upgrade, 4 writeback |
| busAddr | output | ADDR_W | Address on the bus while a command is active |
| busIntervene | output | 1 | A dirty owner cache is supplying the bus data |

## Verification
Two things can happen in the same cycle here. First, two cores can raise requests together, so arbitration and serialization coincide. Second, in one bus cycle the requester fills its line while a dirty owner downgrades and memory takes the owner's data. The first case is provoked by two cores writing one address in the same cycle: the bench checks that the response order follows the round-robin pointer and that later reads from every core return the value written last. The second case is provoked by a dirty line being read and then evicted cleanly from both sharers: a read by a third core must then return the value from memory with no intervention flag.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_M = 2'd2
  } lineSt_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_UPGR = 3'd3,
    CMD_WB   = 3'd4
  } busCmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_BUS,
    ST_DONE
  } ctrlState_e;

  typedef struct packed {
    logic    latchReq;
    logic    localWr;
    logic    localRd;
    logic    wbVictim;
    logic    busGo;
    busCmd_e busCmd;
  } ctrlStrb_t;

endpackage

// File: rtl/coh_rr_arbiter.sv
module coh_rr_arbiter #(
  parameter int N_CORES = 2,
  parameter int CORE_W  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CORES-1:0] req,
  input  logic               advance,
  output logic               anyReq,
  output logic [CORE_W-1:0]  grant
);

  logic [CORE_W-1:0] prioQ;

  always_comb begin
    anyReq = 1'b0;
    grant  = '0;
    for (int i = 0; i < N_CORES; i++) begin
      int cand;
      cand = int'(prioQ) + i;
      if (cand >= N_CORES) cand = cand - N_CORES;
      if (!anyReq && req[cand]) begin
        anyReq = 1'b1;
        grant  = CORE_W'(cand);
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prioQ <= '0;
    end else if (advance) begin
      prioQ <= (grant == CORE_W'(N_CORES - 1)) ? '0 : grant + 1'b1;
    end
  end

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int N_CORES = 2,
  parameter int CORE_W  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CORES-1:0] reqValid,
  input  logic               lkHit,
  input  logic               lkLineM,
  input  logic               opWrite,
  output ctrlStrb_t          strb,
  output logic [CORE_W-1:0]  curCore,
  output logic [CORE_W-1:0]  grantNow,
  output logic [N_CORES-1:0] respValid
);

  ctrlState_e        stQ, nextSt;
  logic [CORE_W-1:0] curQ;
  logic [N_CORES-1:0] respQ;
  logic              anyReq;
  logic              finish;

  coh_rr_arbiter #(.N_CORES(N_CORES), .CORE_W(CORE_W)) uArb (
    .clk    (clk),
    .rst    (rst),
    .req    (reqValid),
    .advance(strb.latchReq),
    .anyReq (anyReq),
    .grant  (grantNow)
  );

  always_comb begin
    strb   = '0;
    nextSt = stQ;
    finish = 1'b0;
    case (stQ)
      ST_IDLE: begin
        if (anyReq) begin
          strb.latchReq = 1'b1;
          nextSt        = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (lkHit && (!opWrite || lkLineM)) begin
          strb.localWr = opWrite;
          strb.localRd = !opWrite;
          finish       = 1'b1;
          nextSt       = ST_DONE;
        end else if (lkLineM && !lkHit) begin
          nextSt = ST_WB;
        end else begin
          nextSt = ST_BUS;
        end
      end
      ST_WB: begin
        strb.wbVictim = 1'b1;
        strb.busCmd   = CMD_WB;
        nextSt        = ST_BUS;
      end
      ST_BUS: begin
        strb.busGo  = 1'b1;
        strb.busCmd = !opWrite ? CMD_RD : (lkHit ? CMD_UPGR : CMD_RDX);
        finish      = 1'b1;
        nextSt      = ST_DONE;
      end
      ST_DONE: nextSt = ST_IDLE;
      default: nextSt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stQ   <= ST_IDLE;
      curQ  <= '0;
      respQ <= '0;
    end else begin
      stQ <= nextSt;
      if (strb.latchReq) curQ <= grantNow;
      if (finish)             respQ <= N_CORES'(1) << curQ;
      else if (stQ == ST_DONE) respQ <= '0;
    end
  end

  assign curCore   = curQ;
  assign respValid = respQ;

endmodule

// File: rtl/coh_datapath.sv
module coh_datapath
  import coh_pkg::*;
#(
  parameter int N_CORES = 2,
  parameter int CORE_W  = 1,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctrlStrb_t                  strb,
  input  logic [CORE_W-1:0]          curCore,
  input  logic [CORE_W-1:0]          grantNow,
  input  logic [N_CORES-1:0]         reqWrite,
  input  logic [N_CORES*ADDR_W-1:0]  reqAddr,
  input  logic [N_CORES*DATA_W-1:0]  reqWData,
  output logic                       lkHit,
  output logic                       lkLineM,
  output logic                       opWrite,
  output logic [DATA_W-1:0]          respWord,
  output logic [ADDR_W-1:0]          busAddr,
  output logic                       busIntervene
);

  localparam int TAG_W     = ADDR_W - IDX_W;
  localparam int LINES     = 1 << IDX_W;
  localparam int MEM_WORDS = 1 << ADDR_W;

  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] opData;
  logic [DATA_W-1:0] respQ;
  logic [IDX_W-1:0]  lkIdx;
  logic [TAG_W-1:0]  lkTag;

  lineSt_e           coreSt  [N_CORES];
  logic [TAG_W-1:0]  coreTag [N_CORES];
  logic [DATA_W-1:0] coreDat [N_CORES];
  logic [N_CORES-1:0] coreMatch;

  logic [DATA_W-1:0] memQ [MEM_WORDS];
  logic              ownerHit;
  logic [DATA_W-1:0] ownerData;
  logic [DATA_W-1:0] fillData;
  lineSt_e           curSt;
  logic [TAG_W-1:0]  curTag;
  logic [DATA_W-1:0] curDat;

  assign lkIdx = opAddr[IDX_W-1:0];
  assign lkTag = opAddr[ADDR_W-1:IDX_W];

  // latched request of the granted core
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      opWrite <= 1'b0;
      opAddr  <= '0;
      opData  <= '0;
    end else if (strb.latchReq) begin
      opWrite <= reqWrite[grantNow];
      opAddr  <= reqAddr[int'(grantNow)*ADDR_W +: ADDR_W];
      opData  <= reqWData[int'(grantNow)*DATA_W +: DATA_W];
    end
  end

  // one private cache per core: requester update or snoop reaction
  for (genvar c = 0; c < N_CORES; c++) begin : gCore
    lineSt_e           stQ  [LINES];
    logic [TAG_W-1:0]  tagQ [LINES];
    logic [DATA_W-1:0] datQ [LINES];
    logic              isCur;

    assign isCur        = (curCore == CORE_W'(c));
    assign coreSt[c]    = stQ[lkIdx];
    assign coreTag[c]   = tagQ[lkIdx];
    assign coreDat[c]   = datQ[lkIdx];
    assign coreMatch[c] = (stQ[lkIdx] != LINE_I) && (tagQ[lkIdx] == lkTag);

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        for (int l = 0; l < LINES; l++) begin
          stQ[l]  <= LINE_I;
          tagQ[l] <= '0;
          datQ[l] <= '0;
        end
      end else if (isCur) begin
        if (strb.localWr) begin
          datQ[lkIdx] <= opData;
          stQ[lkIdx]  <= LINE_M;
        end else if (strb.busGo) begin
          tagQ[lkIdx] <= lkTag;
          datQ[lkIdx] <= opWrite ? opData : fillData;
          stQ[lkIdx]  <= opWrite ? LINE_M : LINE_S;
        end
      end else if (strb.busGo && coreMatch[c]) begin
        if (strb.busCmd == CMD_RD) begin
          if (stQ[lkIdx] == LINE_M) stQ[lkIdx] <= LINE_S;
        end else begin
          stQ[lkIdx] <= LINE_I;
        end
      end
    end
  end

  // dirty owner among the other caches
  always_comb begin
    ownerHit  = 1'b0;
    ownerData = '0;
    for (int c = 0; c < N_CORES; c++) begin
      if (CORE_W'(c) != curCore && coreMatch[c] && coreSt[c] == LINE_M) begin
        ownerHit  = 1'b1;
        ownerData = ownerData | coreDat[c];
      end
    end
  end

  assign curSt    = coreSt[curCore];
  assign curTag   = coreTag[curCore];
  assign curDat   = coreDat[curCore];
  assign fillData = ownerHit ? ownerData : memQ[opAddr];
  assign lkHit    = coreMatch[curCore];
  assign lkLineM  = (curSt == LINE_M);

  // backing memory: victim writeback and owner downgrade
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int w = 0; w < MEM_WORDS; w++) memQ[w] <= '0;
    end else if (strb.wbVictim) begin
      memQ[{curTag, lkIdx}] <= curDat;
    end else if (strb.busGo && strb.busCmd == CMD_RD && ownerHit) begin
      memQ[opAddr] <= ownerData;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                 respQ <= '0;
    else if (strb.localRd)   respQ <= curDat;
    else if (strb.localWr)   respQ <= opData;
    else if (strb.busGo)     respQ <= opWrite ? opData : fillData;
  end

  assign respWord     = respQ;
  assign busAddr      = strb.wbVictim ? {curTag, lkIdx}
                      : (strb.busCmd != CMD_NONE ? opAddr : '0);
  assign busIntervene = strb.busGo && ownerHit &&
                        (strb.busCmd == CMD_RD || strb.busCmd == CMD_RDX);

endmodule

// File: rtl/snoopy_coh.sv
module snoopy_coh
  import coh_pkg::*;
#(
  parameter int N_CORES = 2,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_CORES-1:0]        reqValid,
  input  logic [N_CORES-1:0]        reqWrite,
  input  logic [N_CORES*ADDR_W-1:0] reqAddr,
  input  logic [N_CORES*DATA_W-1:0] reqWData,
  output logic [N_CORES-1:0]        respValid,
  output logic [N_CORES*DATA_W-1:0] respData,
  output logic [2:0]                busCmd,
  output logic [ADDR_W-1:0]         busAddr,
  output logic                      busIntervene
);

  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  ctrlStrb_t         strb;
  logic [CORE_W-1:0] curCore;
  logic [CORE_W-1:0] grantNow;
  logic              lkHit;
  logic              lkLineM;
  logic              opWrite;
  logic [DATA_W-1:0] respWord;

  coh_ctrl #(.N_CORES(N_CORES), .CORE_W(CORE_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .lkHit    (lkHit),
    .lkLineM  (lkLineM),
    .opWrite  (opWrite),
    .strb     (strb),
    .curCore  (curCore),
    .grantNow (grantNow),
    .respValid(respValid)
  );

  coh_datapath #(
    .N_CORES(N_CORES), .CORE_W(CORE_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) uPath (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .curCore     (curCore),
    .grantNow    (grantNow),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqWData    (reqWData),
    .lkHit       (lkHit),
    .lkLineM     (lkLineM),
    .opWrite     (opWrite),
    .respWord    (respWord),
    .busAddr     (busAddr),
    .busIntervene(busIntervene)
  );

  assign respData = {N_CORES{respWord}};
  assign busCmd   = strb.busCmd;

endmodule

// File: rtl/snoopy_coh_check.sv
module snoopy_coh_check #(
  parameter int N_CORES = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [N_CORES-1:0] reqValid,
  input logic [N_CORES-1:0] respValid,
  input logic [2:0]         busCmd,
  input logic               busIntervene
);

  AST_RESP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(respValid)); // R10

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    (|respValid) |=> (respValid == '0)); // R10

  AST_INTV_CMD: assert property (@(posedge clk) disable iff (rst)
    busIntervene |-> (busCmd == 3'd1 || busCmd == 3'd2)); // R7

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
    (busCmd == 3'd4) |=> (busCmd == 3'd1 || busCmd == 3'd2)); // R8

  AST_BUS_THEN_RESP: assert property (@(posedge clk) disable iff (rst)
    (busCmd == 3'd1 || busCmd == 3'd2 || busCmd == 3'd3) |=> $onehot(respValid)); // R2

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    busCmd <= 3'd4); // R9

  for (genvar c = 0; c < N_CORES; c++) begin : gReq
    AST_RESP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
      respValid[c] |-> $past(reqValid[c])); // R10
  end

endmodule

bind snoopy_coh snoopy_coh_check #(.N_CORES(N_CORES)) uCheck (
  .clk         (clk),
  .rst         (rst),
  .reqValid    (reqValid),
  .respValid   (respValid),
  .busCmd      (busCmd),
  .busIntervene(busIntervene)
);

// File: tb/snoopy_coh_test.sv
`timescale 1ns/1ps
module snoopy_coh_test;

  localparam int NC    = 3;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int IW    = 2;
  localparam int LINES = 1 << IW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NC-1:0]    reqValid = '0;
  logic [NC-1:0]    reqWrite = '0;
  logic [NC*AW-1:0] reqAddr  = '0;
  logic [NC*DW-1:0] reqWData = '0;
  logic [NC-1:0]    respValid;
  logic [NC*DW-1:0] respData;
  logic [2:0]       busCmd;
  logic [AW-1:0]    busAddr;
  logic             busIntervene;

  snoopy_coh #(.N_CORES(NC), .ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWData(reqWData), .respValid(respValid),
    .respData(respData), .busCmd(busCmd), .busAddr(busAddr),
    .busIntervene(busIntervene)
  );

  always #4 clk = ~clk; // 125 MHz

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;

  // behavioural reference: per-core line holder and state, flat golden memory
  int mAddr [NC][LINES];
  int mSt   [NC][LINES]; // 0 invalid, 1 shared, 2 modified
  int gmem  [1 << AW];
  int rrNext = 0;
  int expLat, expData;
  int expQ[$];
  int obsQ[$];
  int orderQ[$];
  int seenData [NC];

  function automatic int enc(int cmd, int a, int intv);
    return cmd * 1000 + a * 10 + intv;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkBus(string tag);
    testsRun++;
    if (obsQ.size() != expQ.size()) begin
      testsFailed++;
      $display("FAIL %s bus event count: actual %0d expected %0d", tag, obsQ.size(), expQ.size());
    end else begin
      for (int i = 0; i < expQ.size(); i++) begin
        if (obsQ[i] != expQ[i]) begin
          testsFailed++;
          $display("FAIL %s bus event %0d: actual %0d expected %0d", tag, i, obsQ[i], expQ[i]);
          break;
        end
      end
    end
  endtask

  task automatic modelStep(int c, bit w, int a, int d);
    int idx, cmd, intv;
    bit hit;
    idx = a % LINES;
    hit = (mSt[c][idx] != 0) && (mAddr[c][idx] == a);
    expQ.delete();
    if (hit && (!w || mSt[c][idx] == 2)) begin
      expLat = 2;
    end else begin
      expLat = 3;
      if (!hit && mSt[c][idx] == 2) begin
        expQ.push_back(enc(4, mAddr[c][idx], 0));
        expLat = 4;
      end
      cmd  = !w ? 1 : (hit ? 3 : 2);
      intv = 0;
      for (int o = 0; o < NC; o++) begin
        if (o != c && mSt[o][idx] != 0 && mAddr[o][idx] == a) begin
          if (mSt[o][idx] == 2 && cmd != 3) intv = 1;
          if (cmd == 1) mSt[o][idx] = 1;
          else          mSt[o][idx] = 0;
        end
      end
      expQ.push_back(enc(cmd, a, intv));
      mAddr[c][idx] = a;
      mSt[c][idx]   = w ? 2 : 1;
    end
    if (w) begin
      gmem[a] = d;
      expData = d;
    end else begin
      expData = gmem[a];
    end
    rrNext = (c + 1) % NC;
  endtask

  always @(negedge clk) begin
    if (!rst && busCmd != 3'd0) obsQ.push_back(enc(int'(busCmd), int'(busAddr), int'(busIntervene)));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      testsFailed++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic access(string tag, int c, bit w, int a, int d);
    int lat;
    modelStep(c, w, a, d);
    obsQ.delete();
    @(negedge clk);
    reqValid[c] = 1'b1;
    reqWrite[c] = w;
    reqAddr[c*AW +: AW]  = AW'(a);
    reqWData[c*DW +: DW] = DW'(d);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!respValid[c] && lat < 12);
    check(tag, lat, expLat, "response latency");
    check(tag, int'(respData[c*DW +: DW]), expData, "response data");
    checkBus(tag);
    reqValid[c] = 1'b0;
    @(negedge clk);
  endtask

  task automatic coreDrive(int c, bit w, int a, int d);
    @(negedge clk);
    reqValid[c] = 1'b1;
    reqWrite[c] = w;
    reqAddr[c*AW +: AW]  = AW'(a);
    reqWData[c*DW +: DW] = DW'(d);
    do @(negedge clk); while (!respValid[c]);
    seenData[c] = int'(respData[c*DW +: DW]);
    orderQ.push_back(c);
    reqValid[c] = 1'b0;
  endtask

  // two cores write one address in the same cycle
  task automatic pairWrite(string tag, int ca, int cb, int a, int da, int db);
    int first, second, allExp[$];
    first = -1;
    for (int i = 0; i < NC; i++) begin
      int k;
      k = (rrNext + i) % NC;
      if (first < 0 && (k == ca || k == cb)) first = k;
    end
    second = (first == ca) ? cb : ca;
    orderQ.delete();
    obsQ.delete();
    fork
      coreDrive(ca, 1'b1, a, da);
      coreDrive(cb, 1'b1, a, db);
    join
    @(negedge clk);
    check(tag, orderQ[0], first, "first granted core");
    modelStep(first, 1'b1, a, (first == ca) ? da : db);
    allExp = expQ;
    modelStep(second, 1'b1, a, (second == ca) ? da : db);
    foreach (expQ[i]) allExp.push_back(expQ[i]);
    expQ = allExp;
    checkBus(tag);
    check(tag, seenData[ca], da, "write response data core a");
    check(tag, seenData[cb], db, "write response data core b");
  endtask

  initial begin
    for (int c = 0; c < NC; c++)
      for (int l = 0; l < LINES; l++) begin
        mAddr[c][l] = 0;
        mSt[c][l]   = 0;
      end
    for (int a = 0; a < (1 << AW); a++) gmem[a] = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(respValid), 0, "response after reset");
    check("R1", int'(busCmd), 0, "bus command after reset");
    check("R1", int'(busIntervene), 0, "intervention after reset");

    access("R1", 0, 1'b0, 5, 0);          // first read from zeroed memory
    access("R2", 1, 1'b0, 5, 0);          // second sharer
    access("R3", 0, 1'b0, 5, 0);          // read hit
    access("R5", 0, 1'b1, 5, 1);          // upgrade from shared
    access("R5", 1, 1'b0, 5, 0);          // invalidated copy misses, gets 1
    access("R5", 0, 1'b1, 5, 2);          // upgrade again
    access("R4", 0, 1'b1, 5, 3);          // silent write hit
    access("R6", 2, 1'b1, 5, 4);          // read-for-ownership from dirty owner
    access("R7", 0, 1'b0, 5, 0);          // dirty owner supplies 4
    access("R6", 2, 1'b1, 9, 7);          // clean victim dropped, write miss
    access("R8", 2, 1'b0, 13, 0);         // dirty victim written back
    access("R8", 1, 1'b0, 9, 0);          // memory holds written-back 7
    access("R6", 0, 1'b1, 2, 85);
    access("R7", 1, 1'b0, 2, 0);          // intervention updates memory
    access("R7", 0, 1'b0, 6, 0);          // clean evictions of address 2
    access("R7", 1, 1'b0, 10, 0);
    access("R7", 2, 1'b0, 2, 0);          // served by memory with 85
    access("R3", 2, 1'b0, 2, 0);

    pairWrite("R9", 0, 1, 3, 17, 34);
    access("R9", 2, 1'b0, 3, 0);
    access("R9", 0, 1'b0, 3, 0);
    pairWrite("R9", 1, 2, 7, 51, 68);
    access("R10", 0, 1'b0, 7, 0);
    access("R10", 1, 1'b0, 7, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule